// File: doc/BRIEF.md
# Multi-Mode Programmable Down-Counter Timer

This block is a synchronous down-counter timer. A 3-bit mode input selects one of four behaviours:

- an interval timer that holds its count while paused, with an active-high pulse;
- the same timer with an active-low pulse;
- a retriggerable one-shot;
- a free-running frequency generator.

A single trigger input does three jobs, depending on the mode. While it is high, it loads the counter (or pauses it). On its falling edge, it arms the countdown. Every edge is seen on rising clock edges. A preset register supplies the load value. It captures the data bus on each clock edge while its strobe is high.

There are two outputs. The pulse output marks the zero count. Its idle level depends on the mode, and its active phase depends on the mode as well. The second output is a divide-by-two signal. It flips each time the pulse output makes its active transition, or, in the one-shot, when the pulse ends. Mode values 0 to 3 park the block. The pulse is then low and the divide-by-two output holds its value. Master reset is asynchronous and active low.

Top module: `prog_down_timer`

## Requirements
- R1: While reset is asserted, the counter is zero, counting is disarmed and the divide-by-two output is 0. The pulse output sits at its idle level: high in mode 5, low in every other mode.
- R2: The preset register takes the data bus on a rising edge with the strobe high. With the strobe low, it keeps its value, and bus changes do not reach later loads.
- R3: With the trigger high at a rising edge, the preset is copied into the counter. The first edge that samples the trigger low after it was high arms the counter. Decrements begin on the edge after that.
- R4: In mode 4 (interval timer), the pulse output idles low. It goes high for exactly one cycle on the edge where the count reaches zero, which is N edges after the arming edge for preset N. The divide-by-two output toggles on that same edge.
- R5: In modes 4 and 5, a high trigger before zero freezes the count. A reload is refused while the count is non-zero, even if the preset has changed. After the next arming edge, counting resumes from the frozen value.
- R6: Mode 5 matches mode 4, except that the pulse output idles high and goes low for one cycle. The divide-by-two output toggles as the pulse output falls.
- R7: In mode 6 (one-shot), the pulse output goes high on the first decrement edge. It goes low on the edge where the count reaches zero, giving a width of N-1 cycles for preset N ≥ 2. The divide-by-two output toggles as the pulse falls.
- R8: In mode 6, a high trigger during the countdown reloads the preset on the next edge and leaves the pulse output unchanged.
- R9: In mode 7 (frequency generator), each zero count gives a one-cycle high pulse and toggles the divide-by-two output. The same edge reloads the preset, so pulses repeat every N cycles until reset.
- R10: In mode 7, a high trigger at a rising edge reloads the preset and forces the pulse output low on that edge.
- R11: In modes 0 to 3, the pulse output stays low and the divide-by-two output keeps its value, whatever the trigger does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low master reset |
| mode_sel | input | 3 | Behaviour select: 4 interval, 5 inverted interval, 6 one-shot, 7 frequency generator, 0-3 parked |
| trig | input | 1 | Load/hold while high, arm on its falling edge |
| preset_in | input | 16 | Preset data bus |
| preset_le | input | 1 | Preset capture strobe |
| pulse_o | output | 1 | Pulse output, idle level set by mode |
| half_o | output | 1 | Divide-by-two output, toggles once per completed count |

## Verification
The assertions assume the following about the inputs:

- The mode select stays fixed from load until the count ends.
- The preset is at least 1, and at least 2 in the one-shot mode.
- The trigger is sampled only on the clock, so pulses shorter than a cycle are outside the contract.

The stimulus keeps within these limits. Every scenario starts with a reset. Mode, preset and trigger change only on falling clock edges, between active edges. No preset of 0, and no preset of 1 in the one-shot mode, is ever loaded.

// File: rtl/tm_pkg.sv
package tm_pkg;

    typedef enum logic [2:0] {
        MODE_PARK0    = 3'd0,
        MODE_PARK1    = 3'd1,
        MODE_PARK2    = 3'd2,
        MODE_PARK3    = 3'd3,
        MODE_INTV     = 3'd4,
        MODE_INTV_INV = 3'd5,
        MODE_ONESHOT  = 3'd6,
        MODE_FREQ     = 3'd7
    } tm_mode_e;

    function automatic logic is_interval(input tm_mode_e m);
        return (m == MODE_INTV) || (m == MODE_INTV_INV);
    endfunction

endpackage

// File: rtl/tm_preset_reg.sv
module tm_preset_reg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] preset_o
);
    logic [WIDTH-1:0] preset_d, preset_q;

    always_comb begin
        preset_d = preset_q;
        if (le) preset_d = data_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) preset_q <= '0;
        else        preset_q <= preset_d;
    end

    assign preset_o = preset_q;

    // R2
    preset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> preset_q == $past(preset_q))
        else $error("preset changed without strobe");

endmodule

// File: rtl/tm_trig_edge.sv
module tm_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic fall_o
);
    logic trig_d, trig_q;

    always_comb trig_d = trig_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_d;
    end

    assign fall_o = trig_q & ~trig_in;

endmodule

// File: rtl/tm_count_core.sv
module tm_count_core
    import tm_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tm_mode_e         mode,
    input  logic             trig,
    input  logic             trig_fall,
    input  logic [WIDTH-1:0] preset,
    output logic             active_o,
    output logic             half_o
);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] ZERO = '0;

    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic             armed;
        logic             active;
        logic             half;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        fire;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        unique case (mode)
            MODE_INTV, MODE_INTV_INV: begin
                st_d.active = 1'b0;
                if (trig) begin
                    st_d.armed = 1'b0;
                    if (st_q.count == ZERO) st_d.count = preset;
                end else if (trig_fall) begin
                    st_d.armed = 1'b1;
                end else if (st_q.armed) begin
                    if (st_q.count == ONE) begin
                        st_d.count  = ZERO;
                        st_d.active = 1'b1;
                        st_d.armed  = 1'b0;
                        fire        = 1'b1;
                    end else if (st_q.count == ZERO) begin
                        st_d.armed = 1'b0;
                    end else begin
                        st_d.count = st_q.count - ONE;
                    end
                end
            end
            MODE_ONESHOT: begin
                if (trig) begin
                    st_d.count = preset;
                    st_d.armed = 1'b0;
                end else if (trig_fall) begin
                    st_d.armed = 1'b1;
                end else if (st_q.armed) begin
                    if (st_q.count <= ONE) begin
                        st_d.count  = ZERO;
                        st_d.active = 1'b0;
                        st_d.armed  = 1'b0;
                        fire        = (st_q.count == ONE);
                    end else begin
                        st_d.count  = st_q.count - ONE;
                        st_d.active = 1'b1;
                    end
                end
            end
            MODE_FREQ: begin
                st_d.active = 1'b0;
                if (trig) begin
                    st_d.count = preset;
                    st_d.armed = 1'b0;
                end else if (trig_fall) begin
                    st_d.armed = 1'b1;
                end else if (st_q.armed) begin
                    if (st_q.count <= ONE) begin
                        st_d.count  = preset;
                        st_d.active = 1'b1;
                        fire        = 1'b1;
                    end else begin
                        st_d.count = st_q.count - ONE;
                    end
                end
            end
            default: begin
                st_d.armed  = 1'b0;
                st_d.active = 1'b0;
            end
        endcase
        st_d.half = st_q.half ^ fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign half_o   = st_q.half;

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_state_chk: assert (st_q.count == ZERO && !st_q.armed && !st_q.active && !st_q.half)
                else $error("state not cleared in reset");
        end
    end

    // R4 R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_interval(mode) && st_q.active) |=> !st_q.active)
        else $error("interval pulse longer than one cycle");

    // R5
    hold_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_interval(mode) && trig && st_q.count != ZERO) |=> st_q.count == $past(st_q.count))
        else $error("count moved during hold");

    // R8
    retrig_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ONESHOT && trig) |=> (st_q.active == $past(st_q.active) && st_q.count == $past(preset)))
        else $error("one-shot retrigger misbehaved");

    // R10
    freq_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FREQ && trig) |=> (!st_q.active && st_q.count == $past(preset)))
        else $error("frequency reload misbehaved");

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode < MODE_INTV) |=> (!st_q.active && st_q.half == $past(st_q.half)))
        else $error("parked mode disturbed outputs");

    // R4
    half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.half != $past(st_q.half)) |-> (st_q.active || $past(st_q.active)))
        else $error("half toggled without pulse edge");

endmodule

// File: rtl/prog_down_timer.sv
module prog_down_timer
    import tm_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_sel,
    input  logic             trig,
    input  logic [WIDTH-1:0] preset_in,
    input  logic             preset_le,
    output logic             pulse_o,
    output logic             half_o
);
    tm_mode_e         mode;
    logic [WIDTH-1:0] preset;
    logic             trig_fall;
    logic             active;

    assign mode = tm_mode_e'(mode_sel);

    tm_preset_reg #(.WIDTH(WIDTH)) u_preset (
        .clk      (clk),
        .rst_n    (rst_n),
        .le       (preset_le),
        .data_in  (preset_in),
        .preset_o (preset)
    );

    tm_trig_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig),
        .fall_o  (trig_fall)
    );

    tm_count_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .trig      (trig),
        .trig_fall (trig_fall),
        .preset    (preset),
        .active_o  (active),
        .half_o    (half_o)
    );

    assign pulse_o = active ^ (mode == MODE_INTV_INV);

endmodule

// File: tb/test_prog_down_timer.sv
module test_prog_down_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [2:0]  mode_sel = 3'd4;
    logic        trig = 1'b0;
    logic [15:0] preset_in = '0;
    logic        preset_le = 1'b0;
    logic        pulse_o, half_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    prog_down_timer i_prog_down_timer (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .trig(trig),
        .preset_in(preset_in), .preset_le(preset_le),
        .pulse_o(pulse_o), .half_o(half_o)
    );

    always #5 clk = ~clk;

    // fields: mode[34:32] preset[31:16] expected delay or width[15:0]
    localparam int NV = 8;
    localparam logic [34:0] VEC [NV] = '{
        {3'd4, 16'd5,  16'd5},
        {3'd4, 16'd1,  16'd1},
        {3'd5, 16'd7,  16'd7},
        {3'd5, 16'd2,  16'd2},
        {3'd6, 16'd4,  16'd3},
        {3'd6, 16'd2,  16'd1},
        {3'd7, 16'd3,  16'd3},
        {3'd7, 16'd12, 16'd12}
    };

    function automatic logic act();
        return (mode_sel == 3'd5) ? ~pulse_o : pulse_o;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    // returns at the negedge after the arming edge
    task automatic load_and_arm(input logic [2:0] m, input logic [15:0] n);
        mode_sel = m; preset_in = n; preset_le = 1'b1; trig = 1'b1;
        @(negedge clk); preset_le = 1'b0;
        @(negedge clk); trig = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_active(output int k);
        k = 0;
        do begin
            @(negedge clk); k++;
        end while (!act() && k < 2000);
    endtask

    initial begin
        int k;
        int w;
        #1 rst_n = 1'b0;
        @(negedge clk);
        // R1 reset levels
        chk("R1 pulse idle low mode4", pulse_o, 0);
        chk("R1 half cleared", half_o, 0);
        mode_sel = 3'd5; #1;
        chk("R1 pulse idle high mode5", pulse_o, 1);
        mode_sel = 3'd4;
        @(negedge clk); rst_n = 1'b1;

        // table walk: R4 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  m;
            logic [15:0] n;
            int          e;
            m = VEC[i][34:32]; n = VEC[i][31:16]; e = int'(VEC[i][15:0]);
            do_reset();
            load_and_arm(m, n);
            if (m == 3'd6) begin
                @(negedge clk);
                chk("R7 one-shot high after first decrement", act(), 1);
                w = 1;
                for (int j = 0; j < 2000; j++) begin
                    @(negedge clk);
                    if (!act()) break;
                    w++;
                end
                chk("R7 one-shot width", w, e);
                chk("R7 half toggled at end", half_o, 1);
            end else begin
                wait_active(k);
                chk((m == 3'd5) ? "R6 inverted delay" : (m == 3'd7) ? "R9 first period" : "R4 delay", k, e);
                chk("R4 R6 R9 half toggled with pulse", half_o, 1);
                @(negedge clk);
                if (m != 3'd7 || n != 16'd1)
                    chk("R4 R6 R9 pulse lasts one cycle", act(), 0);
            end
        end

        // R9 repetition period
        do_reset();
        load_and_arm(3'd7, 16'd4);
        wait_active(k);
        wait_active(k);
        chk("R9 period repeats", k, 4);
        chk("R9 half back to zero", half_o, 0);

        // R10 trigger in frequency mode
        trig = 1'b1;
        @(negedge clk);
        chk("R10 pulse cleared by trigger", act(), 0);
        for (int j = 0; j < 10; j++) @(negedge clk);
        chk("R10 no pulse while held", act(), 0);
        trig = 1'b0;
        @(negedge clk);
        wait_active(k);
        chk("R10 reload gives full period", k, 4);

        // R2 preset held with strobe low
        do_reset();
        mode_sel = 3'd4; preset_in = 16'd6; preset_le = 1'b1;
        @(negedge clk); preset_le = 1'b0; preset_in = 16'd9; trig = 1'b1;
        @(negedge clk);
        @(negedge clk); trig = 1'b0;
        @(negedge clk);
        wait_active(k);
        chk("R2 R3 uses latched preset", k, 6);

        // R5 hold without reload
        do_reset();
        load_and_arm(3'd4, 16'd10);
        for (int j = 0; j < 3; j++) @(negedge clk);
        trig = 1'b1; preset_in = 16'd2; preset_le = 1'b1;
        w = 0;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            preset_le = 1'b0;
            if (act()) w++;
        end
        chk("R5 no pulse during hold", w, 0);
        trig = 1'b0;
        @(negedge clk);
        wait_active(k);
        chk("R5 resumes from frozen count", k, 7);

        // R8 one-shot retrigger
        do_reset();
        load_and_arm(3'd6, 16'd5);
        @(negedge clk); @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        chk("R8 pulse kept during retrigger", act(), 1);
        trig = 1'b0;
        @(negedge clk);
        chk("R8 pulse kept at re-arm", act(), 1);
        w = 0;
        for (int j = 0; j < 2000; j++) begin
            @(negedge clk); w++;
            if (!act()) break;
        end
        chk("R8 reloaded count runs out", w, 5);

        // R11 parked mode
        do_reset();
        load_and_arm(3'd7, 16'd2);
        wait_active(k);
        chk("R11 setup half set", half_o, 1);
        mode_sel = 3'd2;
        w = 0;
        for (int j = 0; j < 20; j++) begin
            trig = j[1];
            @(negedge clk);
            if (pulse_o || !half_o) w++;
        end
        chk("R11 outputs parked", w, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule